// File: doc/BRIEF.md
# Cubemap Face and Coordinate Selector

This unit takes a direction vector given as three single-precision floating-point words (x, y, z) and, under control of an opcode, returns one of three quantities used when a vector is mapped onto a cube: twice the component with the largest magnitude (the major axis), the S coordinate on the selected face, or the T coordinate on the selected face. Each input is a raw 32-bit word that is read as an IEEE-754 single. The output is a raw 32-bit word.

The unit needs no floating-point multiplier. Magnitudes are compared as unsigned integers over the bits below the sign. Multiplying by the sign of a component is an XOR of sign bits, and negating a value inverts its sign bit. Doubling adds one to the exponent, or shifts the mantissa left when the value is denormal. A parameter chooses which of two opcode numberings the unit accepts. The result is registered, and a valid strobe accompanies it one cycle after the input strobe.

Top module: `cube_coord_unit`

## Requirements
- R1: While rst_n is low at a rising clock edge, out_valid and out_word are both cleared to zero by that edge.
- R2: out_valid is high in the cycle after in_valid was high, and low otherwise. out_word changes only in the cycle after an accepted input and holds its value when in_valid is low.
- R3: The major axis is z when |z| >= |y| and |z| >= |x|. Otherwise it is y when |y| >= |x|, and otherwise it is x. Each magnitude is bits [30:0] of the word read as an unsigned integer, so ties go to z first, then y.
- R4: The major-axis operation returns the major component doubled. For a normal value this adds one to the exponent field (bits [30:23]) and keeps the sign (bit 31) and the mantissa (bits [22:0]).
- R5: When doubling a normal value gives an exponent of 255, the result is an infinity with the input's sign (exponent 255, mantissa 0).
- R6: A denormal value (exponent 0, mantissa nonzero) is doubled by shifting bits [22:0] left by one. The top mantissa bit carries into bit 23, the exponent LSB.
- R7: A zero, an infinity or a NaN passes through the major-axis operation unchanged.
- R8: S coordinate: a z-major vector gives x with bit 31 XORed with z's sign, and a y-major vector gives x unchanged. An x-major vector gives z's magnitude with sign NOT(x sign XOR z sign).
- R9: T coordinate: a z-major vector or an x-major vector gives y with bit 31 inverted. A y-major vector gives z's magnitude with sign (y sign XOR z sign).
- R10: With NEW_NUMBERING=0 the opcodes are S=325, T=326 and major axis=327. With NEW_NUMBERING=1 they are 453, 454 and 455. Any other opcode gives out_word=0, and out_valid still follows R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input vector and opcode are valid this cycle |
| op_code | input | 9 | Operation select (numbering set by NEW_NUMBERING) |
| vec_x | input | 32 | x component, single-precision bits |
| vec_y | input | 32 | y component, single-precision bits |
| vec_z | input | 32 | z component, single-precision bits |
| out_valid | output | 1 | Result valid strobe, one cycle after in_valid |
| out_word | output | 32 | Registered result word |

## Verification
The assertions assume that inputs are not NaN whenever the major axis must be decided from real magnitudes. A NaN would make the integer comparison order it above infinity. The rules checked by the properties are the sign rules, the output that is forced to zero and the output that holds, and these depend only on bit patterns, so the properties stay valid for any input word. The directed stimulus uses only finite values or infinities when it exercises axis selection. It places a NaN only as the unique largest magnitude, and it does so to confirm that the value passes through unchanged.

// File: rtl/cube_pkg.sv
// Package: shared types and opcode bases for the cubemap selector.
// Assumes the opcode field is wide enough to hold the largest base + 2.
package cube_pkg;

    // Which component of the vector holds the largest magnitude.
    typedef enum logic [1:0] {
        AXIS_X = 2'd0,
        AXIS_Y = 2'd1,
        AXIS_Z = 2'd2
    } axis_e;

    // Decoded operation.
    typedef enum logic [1:0] {
        SEL_S    = 2'd0,
        SEL_T    = 2'd1,
        SEL_MA   = 2'd2,
        SEL_NONE = 2'd3
    } sel_e;

    // First opcode of each numbering; order within a set is S, T, major axis.
    localparam int OLD_BASE = 325;
    localparam int NEW_BASE = 453;

endpackage

// File: rtl/cube_op_decode.sv
// Module: maps a raw opcode onto an operation select.
// Assumes: NEW_NUMBERING chooses the code set at elaboration time; codes
// outside the chosen set decode to SEL_NONE.
module cube_op_decode
    import cube_pkg::*;
#(
    parameter int OPC_W         = 9,
    parameter bit NEW_NUMBERING = 1'b0
) (
    input  logic [OPC_W-1:0] op_code,
    output sel_e             sel
);

    logic [OPC_W-1:0] code_s;
    logic [OPC_W-1:0] code_t;
    logic [OPC_W-1:0] code_ma;

    // Pick the code constants of the configured numbering.
    generate
        if (NEW_NUMBERING) begin : g_new
            assign code_s  = OPC_W'(NEW_BASE);
            assign code_t  = OPC_W'(NEW_BASE + 1);
            assign code_ma = OPC_W'(NEW_BASE + 2);
        end else begin : g_old
            assign code_s  = OPC_W'(OLD_BASE);
            assign code_t  = OPC_W'(OLD_BASE + 1);
            assign code_ma = OPC_W'(OLD_BASE + 2);
        end
    endgenerate

    // Compare the opcode against the three legal codes.
    always_comb begin
        if (op_code == code_s)       sel = SEL_S;
        else if (op_code == code_t)  sel = SEL_T;
        else if (op_code == code_ma) sel = SEL_MA;
        else                         sel = SEL_NONE;
    end

endmodule

// File: rtl/cube_axis_pick.sv
// Module: chooses the major axis of a vector by magnitude, ties to z then y.
// Assumes: inputs are non-NaN for a meaningful choice; magnitude is the word
// without its sign bit, compared as an unsigned integer.
module cube_axis_pick
    import cube_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0] comp_x,
    input  logic [WORD_W-1:0] comp_y,
    input  logic [WORD_W-1:0] comp_z,
    output axis_e             axis
);

    localparam int MAG_W = WORD_W - 1;
    localparam int N_CMP = 3;

    logic [WORD_W-1:0] comp [N_CMP];
    logic [MAG_W-1:0]  mag  [N_CMP];
    logic              z_wins;
    logic              y_wins;

    assign comp[0] = comp_x;
    assign comp[1] = comp_y;
    assign comp[2] = comp_z;

    // Strip the sign bit of every component.
    generate
        for (genvar i = 0; i < N_CMP; i++) begin : g_mag
            assign mag[i] = comp[i][MAG_W-1:0];
        end
    endgenerate

    // Priority compare: z on ties with either, then y on a tie with x.
    always_comb begin
        z_wins = (mag[2] >= mag[1]) && (mag[2] >= mag[0]);
        y_wins = (mag[1] >= mag[0]);
        if (z_wins)      axis = AXIS_Z;
        else if (y_wins) axis = AXIS_Y;
        else             axis = AXIS_X;
    end

endmodule

// File: rtl/cube_double.sv
// Module: doubles a binary floating-point value without a multiplier.
// Assumes: IEEE layout sign|exponent|mantissa. Normals bump the exponent and
// saturate to a signed infinity; denormals shift left with carry into the
// exponent; zero, infinity and NaN pass through.
module cube_double #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0] dbl_in,
    output logic [EXP_W+MAN_W:0] dbl_out
);

    localparam logic [EXP_W-1:0] EXP_MAX = '1;
    localparam logic [EXP_W-1:0] EXP_TOP = EXP_MAX - 1'b1;

    logic             sgn;
    logic [EXP_W-1:0] ex;
    logic [EXP_W-1:0] ex_inc;
    logic [MAN_W-1:0] mn;

    assign sgn    = dbl_in[EXP_W+MAN_W];
    assign ex     = dbl_in[EXP_W+MAN_W-1:MAN_W];
    assign mn     = dbl_in[MAN_W-1:0];
    assign ex_inc = ex + 1'b1;

    // Select the doubling rule from the value class.
    always_comb begin
        dbl_out = dbl_in;
        if (ex == '0) begin
            if (mn != '0) begin
                dbl_out = {sgn, {(EXP_W-1){1'b0}}, mn, 1'b0};
            end
        end else if (ex != EXP_MAX) begin
            if (ex == EXP_TOP) begin
                dbl_out = {sgn, EXP_MAX, {MAN_W{1'b0}}};
            end else begin
                dbl_out = {sgn, ex_inc, mn};
            end
        end
    end

endmodule

// File: rtl/cube_coord_select.sv
// Module: forms the major-axis, S or T result from the vector and its axis.
// Assumes: sign multiplication is a sign-bit XOR and negation a sign flip;
// SEL_NONE yields zero.
module cube_coord_select
    import cube_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  sel_e                 sel,
    input  axis_e                axis,
    input  logic [EXP_W+MAN_W:0] comp_x,
    input  logic [EXP_W+MAN_W:0] comp_y,
    input  logic [EXP_W+MAN_W:0] comp_z,
    output logic [EXP_W+MAN_W:0] result
);

    localparam int SB    = EXP_W + MAN_W;
    localparam int MAG_W = SB;

    logic [SB:0] major;
    logic [SB:0] major_x2;
    logic        sx;
    logic        sy;
    logic        sz;

    assign sx = comp_x[SB];
    assign sy = comp_y[SB];
    assign sz = comp_z[SB];

    // Route the major component into the doubler.
    always_comb begin
        case (axis)
            AXIS_Z:  major = comp_z;
            AXIS_Y:  major = comp_y;
            default: major = comp_x;
        endcase
    end

    cube_double #(
        .EXP_W (EXP_W),
        .MAN_W (MAN_W)
    ) u_double (
        .dbl_in  (major),
        .dbl_out (major_x2)
    );

    // Apply the per-operation, per-axis signed selection.
    always_comb begin
        result = '0;
        case (sel)
            SEL_MA: result = major_x2;
            SEL_S: begin
                case (axis)
                    AXIS_Z:  result = {sx ^ sz, comp_x[MAG_W-1:0]};
                    AXIS_Y:  result = comp_x;
                    default: result = {~(sx ^ sz), comp_z[MAG_W-1:0]};
                endcase
            end
            SEL_T: begin
                case (axis)
                    AXIS_Y:  result = {sy ^ sz, comp_z[MAG_W-1:0]};
                    default: result = {~sy, comp_y[MAG_W-1:0]};
                endcase
            end
            default: result = '0;
        endcase
    end

endmodule

// File: rtl/cube_coord_unit.sv
// Module: top of the cubemap face and coordinate selector. Decodes the
// opcode, picks the major axis, forms the result and registers it with a
// valid strobe one cycle after in_valid.
// Assumes: synchronous active-low reset; the output holds between results.
module cube_coord_unit
    import cube_pkg::*;
#(
    parameter int EXP_W         = 8,
    parameter int MAN_W         = 23,
    parameter int OPC_W         = 9,
    parameter bit NEW_NUMBERING = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [OPC_W-1:0]     op_code,
    input  logic [EXP_W+MAN_W:0] vec_x,
    input  logic [EXP_W+MAN_W:0] vec_y,
    input  logic [EXP_W+MAN_W:0] vec_z,
    output logic                 out_valid,
    output logic [EXP_W+MAN_W:0] out_word
);

    localparam int WORD_W = EXP_W + MAN_W + 1;

    sel_e              sel;
    axis_e             axis;
    logic [WORD_W-1:0] result;

    cube_op_decode #(
        .OPC_W         (OPC_W),
        .NEW_NUMBERING (NEW_NUMBERING)
    ) u_decode (
        .op_code (op_code),
        .sel     (sel)
    );

    cube_axis_pick #(
        .WORD_W (WORD_W)
    ) u_axis (
        .comp_x (vec_x),
        .comp_y (vec_y),
        .comp_z (vec_z),
        .axis   (axis)
    );

    cube_coord_select #(
        .EXP_W (EXP_W),
        .MAN_W (MAN_W)
    ) u_select (
        .sel    (sel),
        .axis   (axis),
        .comp_x (vec_x),
        .comp_y (vec_y),
        .comp_z (vec_z),
        .result (result)
    );

    // Register the valid strobe every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Capture the result only for an accepted input.
    always_ff @(posedge clk) begin
        if (!rst_n)        out_word <= '0;
        else if (in_valid) out_word <= result;
    end

endmodule

// File: rtl/cube_coord_chk.sv
// Checker: temporal properties of cube_coord_unit at its ports.
// Assumes: the axis-dependent properties are meaningful for non-NaN inputs.
module cube_coord_chk #(
    parameter int EXP_W         = 8,
    parameter int MAN_W         = 23,
    parameter int OPC_W         = 9,
    parameter bit NEW_NUMBERING = 1'b0
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic [OPC_W-1:0]     op_code,
    input logic [EXP_W+MAN_W:0] vec_x,
    input logic [EXP_W+MAN_W:0] vec_y,
    input logic [EXP_W+MAN_W:0] vec_z,
    input logic                 out_valid,
    input logic [EXP_W+MAN_W:0] out_word
);

    localparam int SB   = EXP_W + MAN_W;
    localparam int BASE = NEW_NUMBERING ? 453 : 325;

    logic       is_s;
    logic       is_t;
    logic       is_ma;
    logic       z_big;
    logic       y_big;
    logic       maj_sign;

    assign is_s  = (op_code == OPC_W'(BASE));
    assign is_t  = (op_code == OPC_W'(BASE + 1));
    assign is_ma = (op_code == OPC_W'(BASE + 2));

    assign z_big = (vec_z[SB-1:0] >= vec_y[SB-1:0]) && (vec_z[SB-1:0] >= vec_x[SB-1:0]);
    assign y_big = !z_big && (vec_y[SB-1:0] >= vec_x[SB-1:0]);
    assign maj_sign = z_big ? vec_z[SB] : (y_big ? vec_y[SB] : vec_x[SB]);

    // R1: reset clears both outputs.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_word == '0));

    // R2: strobe follows the input strobe by one cycle.
    a_r2_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r2_valid_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R2: result holds while no input is accepted.
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_word));

    // R4: doubling keeps the major component's sign.
    a_r4_ma_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_ma) |=> (out_word[SB] == $past(maj_sign)));

    // R8: y-major S coordinate is x unchanged.
    a_r8_s_ymajor: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_s && y_big) |=> (out_word == $past(vec_x)));

    // R9: T coordinate is -y unless y is major.
    a_r9_t_neg_y: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_t && !y_big) |=>
        (out_word == {~$past(vec_y[SB]), $past(vec_y[SB-1:0])}));

    // R10: unknown opcodes produce zero.
    a_r10_unknown_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !is_s && !is_t && !is_ma) |=> (out_word == '0));

endmodule

bind cube_coord_unit cube_coord_chk #(
    .EXP_W         (EXP_W),
    .MAN_W         (MAN_W),
    .OPC_W         (OPC_W),
    .NEW_NUMBERING (NEW_NUMBERING)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_code   (op_code),
    .vec_x     (vec_x),
    .vec_y     (vec_y),
    .vec_z     (vec_z),
    .out_valid (out_valid),
    .out_word  (out_word)
);

// File: tb/cube_coord_unit_tb.sv
`timescale 1ns/1ps
module cube_coord_unit_tb;

    localparam logic [8:0] OP_S  = 9'd325;
    localparam logic [8:0] OP_T  = 9'd326;
    localparam logic [8:0] OP_MA = 9'd327;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [8:0]  op_code = '0;
    logic [31:0] vec_x = '0;
    logic [31:0] vec_y = '0;
    logic [31:0] vec_z = '0;
    logic        out_valid;
    logic [31:0] out_word;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cube_coord_unit u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op_code   (op_code),
        .vec_x     (vec_x),
        .vec_y     (vec_y),
        .vec_z     (vec_z),
        .out_valid (out_valid),
        .out_word  (out_word)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // Drive one operation at a falling edge, check it at the next one.
    task automatic run_op(input string req, input logic [8:0] op,
                          input logic [31:0] x, input logic [31:0] y,
                          input logic [31:0] z, input logic [31:0] exp);
        @(negedge clk);
        in_valid = 1'b1; op_code = op; vec_x = x; vec_y = y; vec_z = z;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " valid"}, {31'd0, out_valid}, 32'd1);
        check(req, out_word, exp);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R1 reset valid", {31'd0, out_valid}, 32'd0);
        check("R1 reset word", out_word, 32'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_latency_hold();
        run_op("R2 first", OP_MA, 32'h3F800000, 32'h0, 32'h0, 32'h40000000);
        vec_x = 32'hC1000000;
        @(negedge clk);
        check("R2 idle valid", {31'd0, out_valid}, 32'd0);
        check("R2 idle hold", out_word, 32'h40000000);
    endtask

    task automatic t_priority();
        run_op("R3 tie z", OP_MA, 32'h3F800000, 32'hBF800000, 32'h3F800000, 32'h40000000);
        run_op("R3 tie y", OP_MA, 32'h3F800000, 32'hBF800000, 32'h3F000000, 32'hC0000000);
        run_op("R3 x major", OP_MA, 32'hC0400000, 32'h3F800000, 32'h3F800000, 32'hC0C00000);
    endtask

    task automatic t_double();
        run_op("R4 normal", OP_MA, 32'h3F000000, 32'h3E800000, 32'h3FC00000, 32'h40400000);
        run_op("R5 pos inf", OP_MA, 32'h0, 32'h0, 32'h7F7FFFFF, 32'h7F800000);
        run_op("R5 neg inf", OP_MA, 32'h0, 32'hFF7FFFFF, 32'h0, 32'hFF800000);
        run_op("R6 carry", OP_MA, 32'h0, 32'h0, 32'h00400000, 32'h00800000);
        run_op("R6 shift", OP_MA, 32'h00000001, 32'h0, 32'h0, 32'h00000002);
        run_op("R7 zero", OP_MA, 32'h0, 32'h0, 32'h80000000, 32'h80000000);
        run_op("R7 inf", OP_MA, 32'h0, 32'h0, 32'hFF800000, 32'hFF800000);
        run_op("R7 nan", OP_MA, 32'h3F800000, 32'h7FC00001, 32'h0, 32'h7FC00001);
    endtask

    task automatic t_scoord();
        run_op("R8 z major", OP_S, 32'h40000000, 32'h3F800000, 32'hC0800000, 32'hC0000000);
        run_op("R8 y major", OP_S, 32'hBF800000, 32'h40800000, 32'h40000000, 32'hBF800000);
        run_op("R8 x major", OP_S, 32'hC0800000, 32'h3F800000, 32'h40000000, 32'h40000000);
    endtask

    task automatic t_tcoord();
        run_op("R9 z major", OP_T, 32'h3F800000, 32'h40000000, 32'h40800000, 32'hC0000000);
        run_op("R9 y major", OP_T, 32'h3F800000, 32'hC0800000, 32'h40400000, 32'hC0400000);
        run_op("R9 x major", OP_T, 32'h40800000, 32'hC0000000, 32'h3F800000, 32'h40000000);
    endtask

    task automatic t_opcodes();
        run_op("R10 new code ignored", 9'd453, 32'h3F800000, 32'h0, 32'h0, 32'h0);
        run_op("R10 below set", 9'd324, 32'h3F800000, 32'h0, 32'h0, 32'h0);
        run_op("R10 old ma", OP_MA, 32'h3F800000, 32'h0, 32'h0, 32'h40000000);
    endtask

    initial begin
        t_reset();
        t_latency_hold();
        t_priority();
        t_double();
        t_scoord();
        t_tcoord();
        t_opcodes();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R2 actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule